// File: doc/BRIEF.md
# Audio Clock Ratio Monitor

This block watches the three clocks of a serial audio port: the master clock, the bit shift clock and the frame (left/right) clock. It samples all three with a free-running reference clock that must be at least four times faster than the master clock. It counts master-clock and shift-clock rising edges between successive frame-clock rising edges and judges whether the counts fit a legal clock relationship.

When the ratios fit, the block reports which speed family the port is in. A master clock of 256 frame periods gives normal speed, or double speed when the double-speed strap is high. A master clock of 128 frame periods gives quad speed, which is recognised automatically but only as a slave with the double-speed strap low. A frame clock that stops, or counts that leave the tolerance window, raise an error. The error drops the clocks-good flag. When the error clears, a one-cycle request to re-initialise the downstream datapath is issued.

The surrounding control logic uses `clocks_ok` to gate the output stage. It uses `reinit_req` to restart initialisation after a fault.

Top module: `aud_clk_ratio_mon`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it, `clocks_ok`, `clk_err` and `reinit_req` are 0 and `speed_mode` is 0.
- R2: With 256 master-clock and 64 shift-clock edges per frame, `dbl_speed`=0 and either `master_mode` value, `clocks_ok` becomes 1, `clk_err` stays 0 and `speed_mode` is 0 (normal).
- R3: The same clocks with `dbl_speed`=1 give `speed_mode`=1 (double) with `clocks_ok`=1.
- R4: With 128 master-clock edges per frame, `dbl_speed`=0 and `master_mode`=0, `speed_mode` becomes 2 (quad). With `master_mode`=1 or `dbl_speed`=1 the same clocks are a phase error: `clk_err`=1, `clocks_ok`=0, `speed_mode` unchanged.
- R5: A master-clock count within ±`RATIO_TOL` (default 1) of 256 is accepted; 254 and 258 per frame are phase errors.
- R6: A shift-clock count per frame outside 64±`RATIO_TOL` is a phase error, whatever the master clock does.
- R7: If no frame-clock rising edge is seen for `LOSS_TIMEOUT` reference cycles (default 4096), `clk_err` goes to 1 and `clocks_ok` to 0; a gap shorter than that raises nothing.
- R8: When `clk_err` falls, `reinit_req` is high for exactly one reference cycle.
- R9: A new `speed_mode` value is taken only after two consecutive good frames give the same value; one such frame leaves it unchanged.
- R10: `clocks_ok` and `clk_err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mclk_in | input | 1 | Master clock, asynchronous to `clk` |
| sclk_in | input | 1 | Shift clock, asynchronous to `clk` |
| lrclk_in | input | 1 | Frame clock, asynchronous to `clk` |
| dbl_speed | input | 1 | Double-speed strap |
| master_mode | input | 1 | 1 when the port drives its own clocks |
| clocks_ok | output | 1 | Clock relationship locked and error-free |
| clk_err | output | 1 | Loss of clock or ratio mismatch |
| speed_mode | output | 2 | 0 normal, 1 double, 2 quad |
| reinit_req | output | 1 | One-cycle pulse when the error clears |

## Verification
On every cycle the assertions check several properties. The re-initialise request is a single cycle that follows a falling error. The speed code only moves right after a good frame measurement and never takes the unused value. Quad is never accepted in master mode. A frame edge clears the loss flag. Only the bench scenarios can show that the ratio windows sit at the right counts (the sweep from 254 to 258), that the mode waits for two agreeing frames, and that the timeout fires only after the full gap.

// File: rtl/aud_clk_mon_pkg.sv
// Shared types and helpers for the audio clock ratio monitor.
// Assumes: all users compile this package first.
package aud_clk_mon_pkg;

    // Speed family reported by the monitor; value 3 is unused.
    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_e;

    // True when count a lies within tol of target b.
    function automatic logic within_tol(input int a, input int b, input int tol);
        int diff;
        diff = (a > b) ? (a - b) : (b - a);
        return diff <= tol;
    endfunction

endpackage

// File: rtl/aud_clk_edge_sync.sv
// Brings one asynchronous clock into the reference domain and flags its
// rising edges. Assumes: the input holds each level for at least two
// reference cycles, so no edge is lost.
module aud_clk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: one flop of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= async_in;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Purpose: remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

endmodule

// File: rtl/aud_clk_period_counter.sv
// Counts master- and shift-clock edges between frame-clock rising edges
// and watches for a missing frame clock. A measurement is only issued for
// a complete frame, i.e. after one priming edge. Counts saturate.
// Assumes: edge pulses are single-cycle and already synchronised.
module aud_clk_period_counter #(
    parameter int MCLK_W       = 9,
    parameter int SCLK_W       = 7,
    parameter int LOSS_TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk_rise,
    input  logic              sclk_rise,
    input  logic              frame_rise,
    output logic              meas_valid,
    output logic [MCLK_W-1:0] mclk_count,
    output logic [SCLK_W-1:0] sclk_count,
    output logic              lost
);
    localparam int IDLE_W = $clog2(LOSS_TIMEOUT + 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOSS_TIMEOUT - 1);

    logic [MCLK_W-1:0] m_run;
    logic [SCLK_W-1:0] s_run;
    logic [MCLK_W-1:0] m_final;
    logic [SCLK_W-1:0] s_final;
    logic [IDLE_W-1:0] idle_cnt;
    logic              primed;

    // Purpose: running totals including an edge that coincides with the frame edge.
    always_comb begin
        m_final = m_run;
        s_final = s_run;
        if (mclk_rise && (m_run != '1)) m_final = m_run + 1'b1;
        if (sclk_rise && (s_run != '1)) s_final = s_run + 1'b1;
    end

    // Purpose: per-frame edge counting and capture at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_run      <= '0;
            s_run      <= '0;
            mclk_count <= '0;
            sclk_count <= '0;
            meas_valid <= 1'b0;
        end else if (frame_rise) begin
            mclk_count <= m_final;
            sclk_count <= s_final;
            meas_valid <= primed;
            m_run      <= '0;
            s_run      <= '0;
        end else begin
            m_run      <= m_final;
            s_run      <= s_final;
            meas_valid <= 1'b0;
        end
    end

    // Purpose: frame-clock watchdog; a timeout drops the priming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            lost     <= 1'b0;
            primed   <= 1'b0;
        end else if (frame_rise) begin
            idle_cnt <= '0;
            lost     <= 1'b0;
            primed   <= 1'b1;
        end else if (idle_cnt != IDLE_LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end else begin
            lost     <= 1'b1;
            primed   <= 1'b0;
        end
    end

    // R7
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && frame_rise) |=> !lost);

    // R7
    no_meas_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |=> !meas_valid);

endmodule

// File: rtl/aud_clk_ratio_judge.sv
// Classifies one frame's edge counts into a speed family or a fault.
// Purely combinational. Assumes: counts are saturated, never wrapped.
module aud_clk_ratio_judge
    import aud_clk_mon_pkg::*;
#(
    parameter int MCLK_W      = 9,
    parameter int SCLK_W      = 7,
    parameter int MCLK_RATIO  = 256,
    parameter int SCLK_RATIO  = 64,
    parameter int RATIO_TOL   = 1
) (
    input  logic [MCLK_W-1:0] mclk_count,
    input  logic [SCLK_W-1:0] sclk_count,
    input  logic              dbl_speed,
    input  logic              master_mode,
    output logic              good,
    output speed_e            cand
);
    localparam int MCLK_HALF = MCLK_RATIO / 2;

    logic sclk_fit;
    logic mclk_full;
    logic mclk_half;

    // Purpose: compare counts with the legal ratios and pick the candidate mode.
    always_comb begin
        sclk_fit  = within_tol(int'(sclk_count), SCLK_RATIO, RATIO_TOL);
        mclk_full = within_tol(int'(mclk_count), MCLK_RATIO, RATIO_TOL);
        mclk_half = within_tol(int'(mclk_count), MCLK_HALF, RATIO_TOL);
        good = 1'b0;
        cand = SPD_NORMAL;
        if (sclk_fit && mclk_full) begin
            good = 1'b1;
            cand = dbl_speed ? SPD_DOUBLE : SPD_NORMAL;
        end else if (sclk_fit && mclk_half && !dbl_speed && !master_mode) begin
            good = 1'b1;
            cand = SPD_QUAD;
        end
    end

endmodule

// File: rtl/aud_clk_mode_tracker.sv
// Holds the accepted speed mode, the fault state and the re-initialise
// pulse. A mode is taken after two consecutive good frames agree.
// Assumes: meas_valid is a single-cycle pulse per complete frame.
module aud_clk_mode_tracker
    import aud_clk_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       meas_valid,
    input  logic       good,
    input  speed_e     cand,
    input  logic       lost,
    output logic       clocks_ok,
    output logic       clk_err,
    output logic [1:0] speed_mode,
    output logic       reinit_req
);
    speed_e mode_q;
    speed_e prev_cand;
    logic   prev_good;
    logic   locked;
    logic   phase_bad;
    logic   err_q;

    // Purpose: frame-by-frame mode acceptance and phase-fault tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= SPD_NORMAL;
            prev_cand <= SPD_NORMAL;
            prev_good <= 1'b0;
            locked    <= 1'b0;
            phase_bad <= 1'b0;
        end else if (lost) begin
            prev_good <= 1'b0;
            locked    <= 1'b0;
        end else if (meas_valid) begin
            if (good) begin
                phase_bad <= 1'b0;
                prev_good <= 1'b1;
                prev_cand <= cand;
                if (prev_good && (prev_cand == cand)) begin
                    mode_q <= cand;
                    locked <= 1'b1;
                end
            end else begin
                phase_bad <= 1'b1;
                prev_good <= 1'b0;
                locked    <= 1'b0;
            end
        end
    end

    assign clk_err    = lost | phase_bad;
    assign clocks_ok  = locked & ~clk_err;
    assign speed_mode = mode_q;

    // Purpose: one-cycle request when the fault condition goes away.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= 1'b0;
            reinit_req <= 1'b0;
        end else begin
            err_q      <= clk_err;
            reinit_req <= err_q & ~clk_err;
        end
    end

    // R8
    reinit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req |=> !reinit_req);

    // R8
    reinit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req |-> ($past(clk_err, 2) && !$past(clk_err)));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed_mode) |-> $past(meas_valid && good));

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        speed_mode != 2'b11);

endmodule

// File: rtl/aud_clk_ratio_mon.sv
// Top of the audio clock ratio monitor: synchronises the three port
// clocks, measures one frame at a time, classifies it and reports status.
// Assumes: clk runs at least four times faster than the master clock.
module aud_clk_ratio_mon
    import aud_clk_mon_pkg::*;
#(
    parameter int MCLK_RATIO   = 256,
    parameter int SCLK_RATIO   = 64,
    parameter int RATIO_TOL    = 1,
    parameter int LOSS_TIMEOUT = 4096,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclk_in,
    input  logic       sclk_in,
    input  logic       lrclk_in,
    input  logic       dbl_speed,
    input  logic       master_mode,
    output logic       clocks_ok,
    output logic       clk_err,
    output logic [1:0] speed_mode,
    output logic       reinit_req
);
    localparam int MCLK_W  = $clog2(MCLK_RATIO * 2);
    localparam int SCLK_W  = $clog2(SCLK_RATIO * 2);
    localparam int N_CLKS  = 3;

    logic [N_CLKS-1:0] raw_clks;
    logic [N_CLKS-1:0] rises;
    logic              meas_valid;
    logic [MCLK_W-1:0] mclk_count;
    logic [SCLK_W-1:0] sclk_count;
    logic              lost;
    logic              good;
    speed_e            cand;

    assign raw_clks = {lrclk_in, sclk_in, mclk_in};

    generate
        for (genvar k = 0; k < N_CLKS; k++) begin : g_sync
            aud_clk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (raw_clks[k]),
                .rise     (rises[k])
            );
        end
    endgenerate

    aud_clk_period_counter #(
        .MCLK_W       (MCLK_W),
        .SCLK_W       (SCLK_W),
        .LOSS_TIMEOUT (LOSS_TIMEOUT)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .mclk_rise  (rises[0]),
        .sclk_rise  (rises[1]),
        .frame_rise (rises[2]),
        .meas_valid (meas_valid),
        .mclk_count (mclk_count),
        .sclk_count (sclk_count),
        .lost       (lost)
    );

    aud_clk_ratio_judge #(
        .MCLK_W     (MCLK_W),
        .SCLK_W     (SCLK_W),
        .MCLK_RATIO (MCLK_RATIO),
        .SCLK_RATIO (SCLK_RATIO),
        .RATIO_TOL  (RATIO_TOL)
    ) u_judge (
        .mclk_count  (mclk_count),
        .sclk_count  (sclk_count),
        .dbl_speed   (dbl_speed),
        .master_mode (master_mode),
        .good        (good),
        .cand        (cand)
    );

    aud_clk_mode_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .good       (good),
        .cand       (cand),
        .lost       (lost),
        .clocks_ok  (clocks_ok),
        .clk_err    (clk_err),
        .speed_mode (speed_mode),
        .reinit_req (reinit_req)
    );

    // R4
    quad_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && good && (cand == SPD_QUAD)) |-> !master_mode);

    // R10
    ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clocks_ok |-> !lost);

endmodule

// File: tb/aud_clk_ratio_mon_test.sv
module aud_clk_ratio_mon_test;
    localparam int CLK_P   = 10;
    localparam int TIMEOUT = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk_in = 1'b0, sclk_in = 1'b0, lrclk_in = 1'b0;
    logic dbl_speed = 1'b0, master_mode = 1'b0;
    logic clocks_ok, clk_err, reinit_req;
    logic [1:0] speed_mode;

    int flen = 1024, mper = 4, sper = 16;
    bit run = 1'b1;
    int t = 0;
    int n_cmp = 0, n_bad = 0;
    int reinit_total = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    aud_clk_ratio_mon uut (
        .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .sclk_in(sclk_in),
        .lrclk_in(lrclk_in), .dbl_speed(dbl_speed), .master_mode(master_mode),
        .clocks_ok(clocks_ok), .clk_err(clk_err), .speed_mode(speed_mode),
        .reinit_req(reinit_req)
    );

    // Port clock generator, stepped on the falling reference edge.
    always @(negedge clk) begin
        if (run) begin
            t = (t + 1) % flen;
            mclk_in  = (t % mper) >= (mper / 2);
            sclk_in  = (t % sper) >= (sper / 2);
            lrclk_in = (t < flen / 2);
        end
        if (reinit_req) reinit_total = reinit_total + 1;
    end

    function automatic bit near1(input int a, input int b);
        return ((a > b) ? a - b : b - a) <= 1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic wait_t(input int x);
        do @(posedge clk); while (t != x);
        #(CLK_P/4);
    endtask

    // Expected {ok, err, mode} from the clock configuration after reset.
    function automatic logic [3:0] expect_status(input int fl, input int mp, input int sp,
                                                 input bit dbl, input bit ms);
        int mc, sc;
        bit full, half, good;
        logic [1:0] md;
        mc = fl / mp;
        sc = fl / sp;
        full = near1(mc, 256);
        half = near1(mc, 128);
        good = near1(sc, 64) && (full || (half && !dbl && !ms));
        md = !good ? 2'd0 : (full ? (dbl ? 2'd1 : 2'd0) : 2'd2);
        return {good, !good, md};
    endfunction

    task automatic run_case(input string req, input int fl, input int mp, input int sp,
                            input bit dbl, input bit ms);
        flen = fl; mper = mp; sper = sp; dbl_speed = dbl; master_mode = ms;
        rst_n = 1'b0;
        cycles(1200);
        rst_n = 1'b1;
        cycles(5 * fl + 100);
        check(req, {28'd0, clocks_ok, clk_err, speed_mode}, {28'd0, expect_status(fl, mp, sp, dbl, ms)});
    endtask

    initial begin
        int r0;
        // R1: reset state
        cycles(50);
        check("R1 reset", {28'd0, clocks_ok, clk_err, speed_mode, reinit_req},
              {32'd0});
        rst_n = 1'b1;
        cycles(3);
        check("R1 after release", {29'd0, clocks_ok, clk_err, reinit_req}, 32'd0);

        run_case("R2 normal slave",   1024, 4, 16, 1'b0, 1'b0);
        run_case("R2 normal master",  1024, 4, 16, 1'b0, 1'b1);
        run_case("R3 double slave",   1024, 4, 16, 1'b1, 1'b0);
        run_case("R3 double master",  1024, 4, 16, 1'b1, 1'b1);
        run_case("R4 quad slave",      512, 4,  8, 1'b0, 1'b0);
        run_case("R4 quad master",     512, 4,  8, 1'b0, 1'b1);
        run_case("R4 quad dbl",        512, 4,  8, 1'b1, 1'b0);
        for (int n = 254; n <= 258; n++)
            run_case("R5 mclk sweep", 4 * n, 4, 16, 1'b0, 1'b0);
        run_case("R6 sclk 32/frame",  1024, 4, 32, 1'b0, 1'b0);
        run_case("R6 sclk 128/frame", 1024, 4,  8, 1'b0, 1'b0);

        // R7/R8: loss of frame clock and recovery, from a locked state
        run_case("R2 relock", 1024, 4, 16, 1'b0, 1'b0);
        r0 = reinit_total;
        run = 1'b0;
        cycles(2000);
        check("R7 short gap", {30'd0, clocks_ok, clk_err}, {30'd0, 2'b10});
        cycles(TIMEOUT);
        check("R7 timeout", {30'd0, clocks_ok, clk_err}, {30'd0, 2'b01});
        run = 1'b1;
        cycles(4 * 1024);
        check("R8 one pulse after loss", reinit_total - r0, 1);
        check("R7 recovered", {30'd0, clocks_ok, clk_err}, {30'd0, 2'b10});

        // R6/R8: shift clock fault without reset, then repair
        wait_t(0);
        sper = 32;
        cycles(3 * 1024 + 100);
        check("R6 runtime sclk fault", {30'd0, clocks_ok, clk_err}, {30'd0, 2'b01});
        r0 = reinit_total;
        wait_t(0);
        sper = 16;
        cycles(4 * 1024);
        check("R8 one pulse after repair", reinit_total - r0, 1);
        check("R10 ok back", {30'd0, clocks_ok, clk_err}, {30'd0, 2'b10});

        // R9: mode switches only after two agreeing frames
        wait_t(512);
        dbl_speed = 1'b1;
        wait_t(512);
        check("R9 one frame", {30'd0, speed_mode}, 32'd0);
        wait_t(512);
        check("R9 two frames", {30'd0, speed_mode}, 32'd1);
        check("R9 ok kept", {31'd0, clocks_ok}, 32'd1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule